// File: doc/BRIEF.md
# Clock and Reset Control Register File

This block is the software-visible register file of a chip's clock and reset controller. It sits on a 32-bit APB slave port and holds nine words. One configures the crystal oscillator. Three hold the first configuration word of a PLL: core, memory and Ethernet. Two hold the second configuration word of the memory and Ethernet PLLs. The last three are a core clock selector, a peripheral reset word and a clock mux status word. No real oscillator or PLL is behind it. The status bits that boot firmware polls (oscillator ready, PLL lock) and the internal-feedback select bit always read as set, so firmware that waits on them moves on at once.

Every register drives an output port of the same name. Neighbouring logic (clock muxes, reset synchronisers) uses these ports directly. The word on a port is always the word that a read at that register's offset returns.

Top module: `clkrst_regs`

## Requirements
- R1: The registers sit at fixed byte offsets inside a 4 KiB window: oscillator 0x000, core PLL word 0 0x004, memory PLL word 0 0x00C, memory PLL word 1 0x010, Ethernet PLL word 0 0x01C, Ethernet PLL word 1 0x020, core clock select 0x024, peripheral reset 0x028, mux status 0x02C. A read at an offset returns that register.
- R2: A full-word write to the oscillator register stores the written data with bit 31 (ready) forced to 1.
- R3: A full-word write to any PLL word 0 register stores the written data with bit 25 (internal feedback) and bit 31 (lock) forced to 1.
- R4: Full-word writes to the PLL word 1, core clock select, peripheral reset and mux status registers store the data unchanged.
- R5: Reset gives these values: oscillator 0xC000_0000 (ready bit 31, enable bit 30); each PLL word 0 is 0x8201_87C1 (bit 0 set, bits 10:6 all ones, bits 16:15 all ones, bits 25 and 31 set); core clock select 0x0000_0001 (reference clock); all other registers zero.
- R6: A read at any offset in the window that is not listed in R1 returns zero. This includes offsets that are not word aligned.
- R7: A write at an unlisted offset changes no register.
- R8: An access whose four byte strobes are not all set is not a word access. As a write it changes no register. As a read it returns zero.
- R9: Every access finishes in its first access-phase cycle: PREADY is always high and PSLVERR is always low.
- R10: A write only takes effect at the clock edge that ends an access phase (PSEL and PENABLE both high). During the setup phase nothing changes. The new value appears on the ports one cycle after that edge, and the next access reads it.
- R11: Each register output port always carries the value that a read of that register returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write, 0 for read |
| paddr | input | 12 | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| pstrb | input | 4 | APB byte strobes |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| osc_cfg | output | 32 | Oscillator configuration |
| core_pll_w0 | output | 32 | Core PLL word 0 |
| mem_pll_w0 | output | 32 | Memory PLL word 0 |
| mem_pll_w1 | output | 32 | Memory PLL word 1 |
| eth_pll_w0 | output | 32 | Ethernet PLL word 0 |
| eth_pll_w1 | output | 32 | Ethernet PLL word 1 |
| core_clk_sel | output | 32 | Core clock select |
| periph_rst | output | 32 | Peripheral reset word |
| mux_status | output | 32 | Clock mux status |

## Verification
There is no hidden state: every register sits on its own output port. A wrong decode or a wrong forcing mask therefore shows on a port in the first cycle after the offending access edge, before any read-back. A status bit that was cleared by mistake, or a write that leaked through a partial strobe or an unlisted offset, is visible on the ports one cycle after the access that caused it. A faulty read mux shows on prdata in the same access phase, and comparing prdata with the matching port localises it.

// File: rtl/clkrst_regs_pkg.sv
package clkrst_regs_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int STRB_W   = DATA_W / 8;
  localparam int NUM_REGS = 9;

  localparam int RG_OSC   = 0;
  localparam int RG_CORE0 = 1;
  localparam int RG_MEM0  = 2;
  localparam int RG_MEM1  = 3;
  localparam int RG_ETH0  = 4;
  localparam int RG_ETH1  = 5;
  localparam int RG_CSEL  = 6;
  localparam int RG_PRST  = 7;
  localparam int RG_MUXST = 8;

  // status bits that read as set whatever software writes
  localparam logic [DATA_W-1:0] OSC_READY  = DATA_W'(32'h8000_0000);
  localparam logic [DATA_W-1:0] OSC_ENABLE = DATA_W'(32'h4000_0000);
  localparam logic [DATA_W-1:0] PLL_LOCK   = DATA_W'(32'h8000_0000);
  localparam logic [DATA_W-1:0] PLL_INTFB  = DATA_W'(32'h0200_0000);
  localparam logic [DATA_W-1:0] PLL_DIVS   = DATA_W'(32'h0001_87C1);

  function automatic logic [ADDR_W-1:0] reg_offset(input int idx);
    case (idx)
      RG_OSC:   return ADDR_W'(12'h000);
      RG_CORE0: return ADDR_W'(12'h004);
      RG_MEM0:  return ADDR_W'(12'h00C);
      RG_MEM1:  return ADDR_W'(12'h010);
      RG_ETH0:  return ADDR_W'(12'h01C);
      RG_ETH1:  return ADDR_W'(12'h020);
      RG_CSEL:  return ADDR_W'(12'h024);
      RG_PRST:  return ADDR_W'(12'h028);
      default:  return ADDR_W'(12'h02C);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_set_mask(input int idx);
    case (idx)
      RG_OSC:                     return OSC_READY;
      RG_CORE0, RG_MEM0, RG_ETH0: return PLL_LOCK | PLL_INTFB;
      default:                    return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_reset_val(input int idx);
    case (idx)
      RG_OSC:                     return OSC_READY | OSC_ENABLE;
      RG_CORE0, RG_MEM0, RG_ETH0: return PLL_LOCK | PLL_INTFB | PLL_DIVS;
      RG_CSEL:                    return DATA_W'(1);
      default:                    return '0;
    endcase
  endfunction

endpackage

// File: rtl/clkrst_addr_dec.sv
module clkrst_addr_dec
  import clkrst_regs_pkg::*;
#(
  parameter int N_REG = NUM_REGS,
  parameter int AW    = ADDR_W,
  parameter int SW    = STRB_W
) (
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [SW-1:0]    pstrb,
  output logic [N_REG-1:0] wr_hit,
  output logic [N_REG-1:0] rd_hit
);

  logic [N_REG-1:0] match;
  logic             word_acc;

  assign word_acc = psel & penable & (&pstrb);

  for (genvar g = 0; g < N_REG; g++) begin : g_match
    localparam logic [AW-1:0] OFS = AW'(reg_offset(g));
    assign match[g] = (paddr == OFS);
  end

  assign wr_hit = match & {N_REG{word_acc &  pwrite}};
  assign rd_hit = match & {N_REG{word_acc & ~pwrite}};

endmodule

// File: rtl/clkrst_reg_word.sv
module clkrst_reg_word #(
  parameter int               W        = 32,
  parameter logic [W-1:0]     RST_VAL  = '0,
  parameter logic [W-1:0]     SET_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (we) begin
      q <= wdata | SET_MASK;
    end
  end

endmodule

// File: rtl/clkrst_rd_mux.sv
module clkrst_rd_mux #(
  parameter int N = 9,
  parameter int W = 32
) (
  input  logic [N-1:0] sel,
  input  logic [W-1:0] words [N],
  output logic [W-1:0] dout
);

  // one-hot AND-OR: no select means zero
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      dout = dout | (words[i] & {W{sel[i]}});
    end
  end

endmodule

// File: rtl/clkrst_regs.sv
module clkrst_regs
  import clkrst_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [STRB_W-1:0] pstrb,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [DATA_W-1:0] osc_cfg,
  output logic [DATA_W-1:0] core_pll_w0,
  output logic [DATA_W-1:0] mem_pll_w0,
  output logic [DATA_W-1:0] mem_pll_w1,
  output logic [DATA_W-1:0] eth_pll_w0,
  output logic [DATA_W-1:0] eth_pll_w1,
  output logic [DATA_W-1:0] core_clk_sel,
  output logic [DATA_W-1:0] periph_rst,
  output logic [DATA_W-1:0] mux_status
);

  logic [NUM_REGS-1:0] wr_hit;
  logic [NUM_REGS-1:0] rd_hit;
  logic [DATA_W-1:0]   regs_q [NUM_REGS];

  clkrst_addr_dec #(
    .N_REG (NUM_REGS),
    .AW    (ADDR_W),
    .SW    (STRB_W)
  ) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pstrb   (pstrb),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    clkrst_reg_word #(
      .W        (DATA_W),
      .RST_VAL  (reg_reset_val(g)),
      .SET_MASK (reg_set_mask(g))
    ) u_word (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_hit[g]),
      .wdata (pwdata),
      .q     (regs_q[g])
    );
  end

  clkrst_rd_mux #(
    .N (NUM_REGS),
    .W (DATA_W)
  ) u_rmux (
    .sel   (rd_hit),
    .words (regs_q),
    .dout  (prdata)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assign osc_cfg      = regs_q[RG_OSC];
  assign core_pll_w0  = regs_q[RG_CORE0];
  assign mem_pll_w0   = regs_q[RG_MEM0];
  assign mem_pll_w1   = regs_q[RG_MEM1];
  assign eth_pll_w0   = regs_q[RG_ETH0];
  assign eth_pll_w1   = regs_q[RG_ETH1];
  assign core_clk_sel = regs_q[RG_CSEL];
  assign periph_rst   = regs_q[RG_PRST];
  assign mux_status   = regs_q[RG_MUXST];

endmodule

// File: rtl/clkrst_regs_chk.sv
module clkrst_regs_chk
  import clkrst_regs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [STRB_W-1:0] pstrb,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr,
  input logic [DATA_W-1:0] osc_cfg,
  input logic [DATA_W-1:0] core_pll_w0,
  input logic [DATA_W-1:0] mem_pll_w0,
  input logic [DATA_W-1:0] mem_pll_w1,
  input logic [DATA_W-1:0] eth_pll_w0,
  input logic [DATA_W-1:0] eth_pll_w1,
  input logic [DATA_W-1:0] core_clk_sel,
  input logic [DATA_W-1:0] periph_rst,
  input logic [DATA_W-1:0] mux_status
);

  logic wacc;
  assign wacc = psel && penable && pwrite && (&pstrb);

  // R2
  p_osc_ready_forced_r2: assert property (@(posedge clk) disable iff (rst)
    (wacc && paddr == 12'h000) |=> osc_cfg == ($past(pwdata) | 32'h8000_0000));

  // R3
  p_core_lock_forced_r3: assert property (@(posedge clk) disable iff (rst)
    (wacc && paddr == 12'h004) |=> core_pll_w0 == ($past(pwdata) | 32'h8200_0000));

  // R4
  p_prst_plain_store_r4: assert property (@(posedge clk) disable iff (rst)
    (wacc && paddr == 12'h028) |=> periph_rst == $past(pwdata));

  // R7, R8, R10: only a full-word access-phase write at its offset moves it
  p_prst_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(wacc && paddr == 12'h028) |=> $stable(periph_rst));

  // R6
  p_unmapped_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pwrite && paddr == 12'h008) |-> prdata == '0);

  // R11
  p_read_matches_port_r11: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pwrite && (&pstrb) && paddr == 12'h02C) |-> prdata == mux_status);

  // R9
  p_handshake_r9: assert property (@(posedge clk) disable iff (rst)
    pready && !pslverr);

  // R5
  p_reset_values_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (osc_cfg == 32'hC000_0000 && core_pll_w0 == 32'h8201_87C1 &&
                    mem_pll_w0 == 32'h8201_87C1 && eth_pll_w0 == 32'h8201_87C1 &&
                    mem_pll_w1 == '0 && eth_pll_w1 == '0 && core_clk_sel == 32'h1 &&
                    periph_rst == '0 && mux_status == '0));

endmodule

bind clkrst_regs clkrst_regs_chk u_chk (.*);

// File: tb/clkrst_regs_bench.sv
`timescale 1ns/1ps
module clkrst_regs_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [31:0] osc_cfg, core_pll_w0, mem_pll_w0, mem_pll_w1, eth_pll_w0,
               eth_pll_w1, core_clk_sel, periph_rst, mux_status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic        cap_rdy, cap_err;

  always #2.5 clk = ~clk;

  clkrst_regs u_clkrst_regs (
    .clk, .rst, .psel, .penable, .pwrite, .paddr, .pwdata, .pstrb,
    .prdata, .pready, .pslverr, .osc_cfg, .core_pll_w0, .mem_pll_w0,
    .mem_pll_w1, .eth_pll_w0, .eth_pll_w1, .core_clk_sel, .periph_rst,
    .mux_status
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0, 4'hF, 32'hC000_0000, 8'd5},
    '{1'b0, 12'h004, 32'h0, 4'hF, 32'h8201_87C1, 8'd5},
    '{1'b0, 12'h00C, 32'h0, 4'hF, 32'h8201_87C1, 8'd5},
    '{1'b0, 12'h01C, 32'h0, 4'hF, 32'h8201_87C1, 8'd5},
    '{1'b0, 12'h024, 32'h0, 4'hF, 32'h0000_0001, 8'd5},
    '{1'b0, 12'h010, 32'h0, 4'hF, 32'h0000_0000, 8'd5},
    '{1'b1, 12'h000, 32'h0000_1234, 4'hF, 32'h0, 8'd2},
    '{1'b0, 12'h000, 32'h0, 4'hF, 32'h8000_1234, 8'd2},
    '{1'b1, 12'h004, 32'h0000_0000, 4'hF, 32'h0, 8'd3},
    '{1'b0, 12'h004, 32'h0, 4'hF, 32'h8200_0000, 8'd3},
    '{1'b1, 12'h00C, 32'h1234_5678, 4'hF, 32'h0, 8'd3},
    '{1'b0, 12'h00C, 32'h0, 4'hF, 32'h9234_5678, 8'd3},
    '{1'b1, 12'h01C, 32'hFFFF_FFFF, 4'hF, 32'h0, 8'd3},
    '{1'b0, 12'h01C, 32'h0, 4'hF, 32'hFFFF_FFFF, 8'd3},
    '{1'b1, 12'h010, 32'hDEAD_BEEF, 4'hF, 32'h0, 8'd4},
    '{1'b0, 12'h010, 32'h0, 4'hF, 32'hDEAD_BEEF, 8'd4},
    '{1'b1, 12'h020, 32'h0000_0100, 4'hF, 32'h0, 8'd4},
    '{1'b0, 12'h020, 32'h0, 4'hF, 32'h0000_0100, 8'd4},
    '{1'b1, 12'h024, 32'h0000_0000, 4'hF, 32'h0, 8'd4},
    '{1'b0, 12'h024, 32'h0, 4'hF, 32'h0000_0000, 8'd4},
    '{1'b1, 12'h028, 32'hA5A5_A5A5, 4'hF, 32'h0, 8'd4},
    '{1'b0, 12'h028, 32'h0, 4'hF, 32'hA5A5_A5A5, 8'd4},
    '{1'b1, 12'h02C, 32'h5A5A_5A5A, 4'hF, 32'h0, 8'd4},
    '{1'b0, 12'h02C, 32'h0, 4'hF, 32'h5A5A_5A5A, 8'd4},
    '{1'b0, 12'h008, 32'h0, 4'hF, 32'h0, 8'd6},
    '{1'b0, 12'h030, 32'h0, 4'hF, 32'h0, 8'd6},
    '{1'b0, 12'h001, 32'h0, 4'hF, 32'h0, 8'd6},
    '{1'b0, 12'hFFC, 32'h0, 4'hF, 32'h0, 8'd6},
    '{1'b0, 12'h028, 32'h0, 4'h7, 32'h0, 8'd8},
    '{1'b0, 12'h004, 32'h0, 4'hF, 32'h8200_0000, 8'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [3:0] s, output logic [31:0] rd);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd = prdata; cap_rdy = pready; cap_err = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic check_ports(input string req, input logic [31:0] e [9]);
    check(req, osc_cfg, e[0]);      check(req, core_pll_w0, e[1]);
    check(req, mem_pll_w0, e[2]);   check(req, mem_pll_w1, e[3]);
    check(req, eth_pll_w0, e[4]);   check(req, eth_pll_w1, e[5]);
    check(req, core_clk_sel, e[6]); check(req, periph_rst, e[7]);
    check(req, mux_status, e[8]);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] rst_vals [9] = '{32'hC000_0000, 32'h8201_87C1, 32'h8201_87C1, 32'h0,
                                  32'h8201_87C1, 32'h0, 32'h1, 32'h0, 32'h0};
    logic [31:0] after_tab [9] = '{32'h8000_1234, 32'h8200_0000, 32'h9234_5678,
                                   32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h0000_0100,
                                   32'h0, 32'hA5A5_A5A5, 32'h5A5A_5A5A};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_ports("R5 reset", rst_vals);

    for (int i = 0; i < NV; i++) begin
      apb(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].strb, rd);
      if (!VECS[i].wr) check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
      check("R9 pready", {31'b0, cap_rdy}, 32'h1);
      check("R9 pslverr", {31'b0, cap_err}, 32'h0);
    end

    // R11: ports hold what was read back
    check_ports("R11 ports", after_tab);

    // R7: writes at unlisted offsets
    apb(1'b1, 12'h008, 32'h1111_1111, 4'hF, rd);
    apb(1'b1, 12'h02A, 32'h2222_2222, 4'hF, rd);
    apb(1'b1, 12'h800, 32'h3333_3333, 4'hF, rd);
    check_ports("R7 unmapped write", after_tab);

    // R8: partial strobe writes
    apb(1'b1, 12'h028, 32'h0, 4'h3, rd);
    apb(1'b1, 12'h000, 32'h0, 4'h0, rd);
    check_ports("R8 partial write", after_tab);

    // R10: setup phase held without enable writes nothing
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h02C;
    pwdata = 32'h0; pstrb = 4'hF;
    repeat (3) @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    @(negedge clk);
    check("R10 setup only", mux_status, 32'h5A5A_5A5A);

    // R10: write visible one cycle after the access edge
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h024;
    pwdata = 32'h0000_0003; pstrb = 4'hF;
    @(negedge clk);
    penable = 1'b1;
    #1 check("R10 before edge", core_clk_sel, 32'h0);
    @(negedge clk);
    check("R10 after edge", core_clk_sel, 32'h0000_0003);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;

    // R2: oscillator write with ready clear still reads ready
    apb(1'b1, 12'h000, 32'h0000_0000, 4'hF, rd);
    apb(1'b0, 12'h000, 32'h0, 4'hF, rd);
    check("R2 osc zero write", rd, 32'h8000_0000);

    // R5: reset mid-run restores power-on values
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_ports("R5 rerun reset", rst_vals);
    apb(1'b0, 12'h004, 32'h0, 4'hF, rd);
    check("R1 core pll readback", rd, 32'h8201_87C1);

    finish_run();
  end

endmodule